// File: doc/BRIEF.md
# PHY Power-Up Sequencer with DLL Lock

This block is a hardware sequencer that brings the analog front end of a storage-interface PHY up or down without software pacing. A one-cycle request starts a sequence: the block first parks the PHY by pulling the power-down-bar line low and then the DLL enable low. A power-down request ends there. A power-up request continues:

- It holds both lines low for a minimum settle time, then releases power-down-bar.
- It gives the calibration pads a fixed trimming window and samples calibration-done exactly once. A missing flag aborts the sequence with the DLL left off.
- It programs a two-bit DLL frequency band and enables the DLL.
- It polls DLL-ready at a fixed interval until the flag appears or a long lock timeout runs out.

The card clock rate, given in Hz, is classified when a request is accepted. The class selects the frequency band and sets a warning flag when the rate is outside the range the DLL can track accurately. All delays are counted in cycles of the reference clock. The parameter `CYC_PER_US` gives the number of reference cycles in one microsecond.

The state machine has these states: `ST_IDLE`, `ST_PDB_DROP`, `ST_DLL_DROP`, `ST_SETTLE`, `ST_PDB_RAISE`, `ST_CAL_WAIT`, `ST_CAL_CHECK`, `ST_FREQ_APPLY`, `ST_DLL_RAISE`, `ST_LOCK_WAIT`, `ST_LOCK_POLL`, `ST_DONE`, `ST_CAL_FAIL` and `ST_LOCK_FAIL`.

Its transitions are:

- `ST_IDLE`→`ST_PDB_DROP` on any request.
- `ST_PDB_DROP`→`ST_DLL_DROP`.
- `ST_DLL_DROP`→`ST_DONE` for a power-down request, or →`ST_SETTLE` for a power-up request.
- `ST_SETTLE`→`ST_PDB_RAISE` when the settle wait expires.
- `ST_PDB_RAISE`→`ST_CAL_WAIT`.
- `ST_CAL_WAIT`→`ST_CAL_CHECK` when the trimming wait expires.
- `ST_CAL_CHECK`→`ST_FREQ_APPLY` if calibration-done is set, otherwise →`ST_CAL_FAIL`.
- `ST_FREQ_APPLY`→`ST_DLL_RAISE`.
- `ST_DLL_RAISE`→`ST_LOCK_WAIT`.
- `ST_LOCK_WAIT`→`ST_LOCK_POLL` when the poll interval expires.
- `ST_LOCK_POLL`→`ST_DONE` if DLL-ready is set, →`ST_LOCK_FAIL` if the lock timeout has expired, otherwise →`ST_LOCK_WAIT`.
- `ST_DONE`, `ST_CAL_FAIL` and `ST_LOCK_FAIL` each return to `ST_IDLE`.

Top module: `phy_pwr_seq`

## Requirements
- R1: A synchronous reset puts the sequencer in idle with `phy_pdb`=0, `phy_dll_en`=0, `phy_freq_sel`=0 and no result pulse.
- R2: Every accepted request drives `phy_pdb` low before `phy_dll_en` goes low. A power-down request then ends with `seq_done` while both lines are low.
- R3: On power-up, `phy_pdb` stays low for at least `PDB_WAIT_US` microseconds before it rises.
- R4: Calibration-done is sampled once, `CAL_WAIT_US` microseconds after `phy_pdb` rises. If the flag is 0, `err_cal` pulses, `phy_dll_en` stays 0 and `phy_pdb` stays 1.
- R5: After calibration succeeds, `phy_freq_sel` takes the band code before `phy_dll_en` rises, and it does not change while `phy_dll_en` is high.
- R6: DLL-ready is polled every `POLL_US` microseconds after the DLL is enabled. When the flag is seen, `seq_done` pulses with both lines high. If the flag is not seen within `DLL_TMO_US` microseconds, `err_dll` pulses.
- R7: The band code depends on the rate:
  - code 1 for rates below 75 MHz;
  - code 2 for rates from 75 MHz up to but not including 125 MHz;
  - code 3 for rates from 125 MHz up to but not including 175 MHz;
  - code 0 for all higher rates, and whenever `rate_valid`=0.
- R8: `rate_warn` is set at acceptance when `rate_valid`=1 and either the rate is above 200 MHz, or the rate is above 50 MHz and more than 15 MHz away from the ideal rate of its band (50, 100, 150 or 200 MHz). It is held until the next accepted request, and the sequence still runs.
- R9: Requests are accepted only in idle and are ignored while a sequence runs. If `req_on` and `req_off` are high together, the request is treated as power-up.
- R10: `seq_done`, `err_cal` and `err_dll` are one-cycle pulses, at most one of them high at a time. The sequencer is idle again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| req_on | input | 1 | Power-up request pulse |
| req_off | input | 1 | Power-down request pulse |
| rate_hz | input | RATE_W | Card clock rate in Hz |
| rate_valid | input | 1 | High when `rate_hz` carries a rate |
| cal_done | input | 1 | Calibration-done flag from the PHY |
| dll_ready | input | 1 | DLL-ready flag from the PHY |
| phy_pdb | output | 1 | Power-down-bar to the PHY |
| phy_dll_en | output | 1 | DLL enable to the PHY |
| phy_freq_sel | output | 2 | DLL frequency band code |
| seq_done | output | 1 | Sequence completed (pulse) |
| err_cal | output | 1 | Calibration timeout (pulse) |
| err_dll | output | 1 | DLL lock timeout (pulse) |
| rate_warn | output | 1 | Unsupported-rate warning |

## Verification
The bench builds the sequencer with `CYC_PER_US`=4 and `DLL_TMO_US`=50, and keeps the default 3 µs settle, 5 µs trimming and 1 µs poll intervals. This scales the real microsecond and millisecond windows down to tens or hundreds of cycles. With these values a PHY model whose calibration or lock delays fall well inside or well outside each window can drive both timeout paths, early and late lock, and requests injected in the middle of a sequence within a short run. Rate classification is exercised at every band edge and warning edge, as well as with random rates.

// File: rtl/phy_pwr_seq_pkg.sv
package phy_pwr_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PDB_DROP,
        ST_DLL_DROP,
        ST_SETTLE,
        ST_PDB_RAISE,
        ST_CAL_WAIT,
        ST_CAL_CHECK,
        ST_FREQ_APPLY,
        ST_DLL_RAISE,
        ST_LOCK_WAIT,
        ST_LOCK_POLL,
        ST_DONE,
        ST_CAL_FAIL,
        ST_LOCK_FAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        BAND_200 = 2'd0,
        BAND_50  = 2'd1,
        BAND_100 = 2'd2,
        BAND_150 = 2'd3
    } band_t;

    typedef struct packed {
        band_t band;
        logic  warn;
    } rate_class_t;

endpackage

// File: rtl/phy_rate_class.sv
module phy_rate_class
    import phy_pwr_seq_pkg::*;
#(
    parameter int RATE_W = 32
) (
    input  logic [RATE_W-1:0] rate_hz,
    input  logic              rate_valid,
    output rate_class_t       cls
);
    localparam logic [63:0] HZ_50M  = 64'd50_000_000;
    localparam logic [63:0] HZ_75M  = 64'd75_000_000;
    localparam logic [63:0] HZ_100M = 64'd100_000_000;
    localparam logic [63:0] HZ_125M = 64'd125_000_000;
    localparam logic [63:0] HZ_150M = 64'd150_000_000;
    localparam logic [63:0] HZ_175M = 64'd175_000_000;
    localparam logic [63:0] HZ_200M = 64'd200_000_000;
    localparam logic [63:0] HZ_TOL  = 64'd15_000_000;

    logic [63:0] rate_w;
    logic [63:0] ideal_hz;
    logic [63:0] dev_hz;
    band_t       band_raw;

    assign rate_w = 64'(rate_hz);

    // Band boundaries are midpoints between ideal rates.
    always_comb begin
        if (rate_w < HZ_75M) begin
            band_raw = BAND_50;
            ideal_hz = HZ_50M;
        end else if (rate_w < HZ_125M) begin
            band_raw = BAND_100;
            ideal_hz = HZ_100M;
        end else if (rate_w < HZ_175M) begin
            band_raw = BAND_150;
            ideal_hz = HZ_150M;
        end else begin
            band_raw = BAND_200;
            ideal_hz = HZ_200M;
        end
    end

    assign dev_hz = (rate_w > ideal_hz) ? (rate_w - ideal_hz) : (ideal_hz - rate_w);

    always_comb begin
        if (rate_valid) begin
            cls.band = band_raw;
            cls.warn = (rate_w > HZ_200M) || ((rate_w > HZ_50M) && (dev_hz > HZ_TOL));
        end else begin
            cls.band = BAND_200;
            cls.warn = 1'b0;
        end
    end

endmodule

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired = (count_q == '0);

    // R6: once run down, the timer stays expired until reloaded
    p_timer_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired);

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
    import phy_pwr_seq_pkg::*;
#(
    parameter int CYC_PER_US  = 100,
    parameter int PDB_WAIT_US = 3,
    parameter int CAL_WAIT_US = 5,
    parameter int POLL_US     = 1,
    parameter int DLL_TMO_US  = 10000,
    parameter int RATE_W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_on,
    input  logic              req_off,
    input  logic [RATE_W-1:0] rate_hz,
    input  logic              rate_valid,
    input  logic              cal_done,
    input  logic              dll_ready,
    output logic              phy_pdb,
    output logic              phy_dll_en,
    output logic [1:0]        phy_freq_sel,
    output logic              seq_done,
    output logic              err_cal,
    output logic              err_dll,
    output logic              rate_warn
);
    localparam int PDB_CYC  = PDB_WAIT_US * CYC_PER_US;
    localparam int CAL_CYC  = CAL_WAIT_US * CYC_PER_US;
    localparam int POLL_CYC = POLL_US * CYC_PER_US;
    localparam int TMO_CYC  = DLL_TMO_US * CYC_PER_US;
    localparam int MAX_AB   = (PDB_CYC > CAL_CYC) ? PDB_CYC : CAL_CYC;
    localparam int MAX_ABC  = (MAX_AB > POLL_CYC) ? MAX_AB : POLL_CYC;
    localparam int MAX_CYC  = (MAX_ABC > TMO_CYC) ? MAX_ABC : TMO_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] PDB_LD  = CNT_W'(PDB_CYC - 1);
    localparam logic [CNT_W-1:0] CAL_LD  = CNT_W'(CAL_CYC - 1);
    localparam logic [CNT_W-1:0] POLL_LD = CNT_W'(POLL_CYC - 1);
    localparam logic [CNT_W-1:0] TMO_LD  = CNT_W'(TMO_CYC - 1);

    seq_state_t       state_q, state_n;
    rate_class_t      cls;
    band_t            band_q;
    band_t            freq_q;
    logic             mode_on_q;
    logic             wait_load, tmo_load;
    logic [CNT_W-1:0] wait_val;
    logic             wait_exp, tmo_exp;
    logic             accept;

    phy_rate_class #(.RATE_W(RATE_W)) u_class (
        .rate_hz    (rate_hz),
        .rate_valid (rate_valid),
        .cls        (cls)
    );

    // Short waits: settle, trimming window, poll interval.
    always_comb begin
        wait_load = (state_n != state_q) &&
                    ((state_n == ST_SETTLE) || (state_n == ST_CAL_WAIT) ||
                     (state_n == ST_LOCK_WAIT));
        unique case (state_n)
            ST_SETTLE:   wait_val = PDB_LD;
            ST_CAL_WAIT: wait_val = CAL_LD;
            default:     wait_val = POLL_LD;
        endcase
    end

    assign tmo_load = (state_n == ST_DLL_RAISE);

    phy_seq_timer #(.CNT_W(CNT_W)) u_wait_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (wait_load),
        .load_val (wait_val),
        .expired  (wait_exp)
    );

    phy_seq_timer #(.CNT_W(CNT_W)) u_lock_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmo_load),
        .load_val (TMO_LD),
        .expired  (tmo_exp)
    );

    assign accept = (state_q == ST_IDLE) && (req_on || req_off);

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_on || req_off) state_n = ST_PDB_DROP;
            ST_PDB_DROP:   state_n = ST_DLL_DROP;
            ST_DLL_DROP:   state_n = mode_on_q ? ST_SETTLE : ST_DONE;
            ST_SETTLE:     if (wait_exp) state_n = ST_PDB_RAISE;
            ST_PDB_RAISE:  state_n = ST_CAL_WAIT;
            ST_CAL_WAIT:   if (wait_exp) state_n = ST_CAL_CHECK;
            ST_CAL_CHECK:  state_n = cal_done ? ST_FREQ_APPLY : ST_CAL_FAIL;
            ST_FREQ_APPLY: state_n = ST_DLL_RAISE;
            ST_DLL_RAISE:  state_n = ST_LOCK_WAIT;
            ST_LOCK_WAIT:  if (wait_exp) state_n = ST_LOCK_POLL;
            ST_LOCK_POLL: begin
                if (dll_ready)    state_n = ST_DONE;
                else if (tmo_exp) state_n = ST_LOCK_FAIL;
                else              state_n = ST_LOCK_WAIT;
            end
            ST_DONE, ST_CAL_FAIL, ST_LOCK_FAIL: state_n = ST_IDLE;
            default:       state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    // Output register: driven by the state being entered
    always_ff @(posedge clk) begin
        if (rst) begin
            phy_pdb    <= 1'b0;
            phy_dll_en <= 1'b0;
            freq_q     <= BAND_200;
            band_q     <= BAND_200;
            mode_on_q  <= 1'b0;
            rate_warn  <= 1'b0;
            seq_done   <= 1'b0;
            err_cal    <= 1'b0;
            err_dll    <= 1'b0;
        end else begin
            seq_done <= (state_n == ST_DONE);
            err_cal  <= (state_n == ST_CAL_FAIL);
            err_dll  <= (state_n == ST_LOCK_FAIL);
            if (accept) begin
                mode_on_q <= req_on;
                band_q    <= cls.band;
                rate_warn <= cls.warn;
            end
            unique case (state_n)
                ST_PDB_DROP:   phy_pdb    <= 1'b0;
                ST_DLL_DROP:   phy_dll_en <= 1'b0;
                ST_PDB_RAISE:  phy_pdb    <= 1'b1;
                ST_FREQ_APPLY: freq_q     <= band_q;
                ST_DLL_RAISE:  phy_dll_en <= 1'b1;
                default: ;
            endcase
        end
    end

    assign phy_freq_sel = freq_q;

    // Checker state: run of cycles with power-down-bar low
    logic [CNT_W-1:0] low_run_q;
    always_ff @(posedge clk) begin
        if (rst)                   low_run_q <= '0;
        else if (phy_pdb)          low_run_q <= '0;
        else if (low_run_q != '1)  low_run_q <= low_run_q + 1'b1;
    end

    // R3: power-down-bar rises only after the full settle time
    p_settle_min_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_pdb) |-> (low_run_q >= CNT_W'(PDB_CYC)));

    // R2: DLL enable only falls once power-down-bar is already low
    p_drop_order_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(phy_dll_en) |-> !phy_pdb);

    // R5: DLL enable rises only with the PHY powered
    p_dll_after_pdb_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_dll_en) |-> phy_pdb);

    // R5: band code is frozen while the DLL runs
    p_freq_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (phy_dll_en && $past(phy_dll_en)) |-> $stable(phy_freq_sel));

    // R4: a calibration failure leaves the DLL off
    p_cal_fail_dll_off_r4: assert property (@(posedge clk) disable iff (rst)
        err_cal |-> (!phy_dll_en && phy_pdb));

    // R10: result pulses are exclusive and last one cycle
    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({seq_done, err_cal, err_dll}));
    p_pulse_short_r10: assert property (@(posedge clk) disable iff (rst)
        (seq_done || err_cal || err_dll) |=> !(seq_done || err_cal || err_dll));

    // R9: a request arriving mid-sequence does not restart it
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        ((state_q != ST_IDLE) && (req_on || req_off)) |=> (state_q != ST_PDB_DROP));

endmodule

// File: tb/phy_pwr_seq_bench.sv
module phy_pwr_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int US         = 4;
    localparam int TMO_US     = 50;
    localparam int SETTLE_MIN = 3 * US;
    localparam int CAL_OK_MAX = 14;
    localparam int CAL_BAD    = 40;
    localparam int DLL_OK_MAX = 150;
    localparam int DLL_BAD    = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_on = 1'b0, req_off = 1'b0;
    logic [31:0] rate_hz = '0;
    logic        rate_valid = 1'b0;
    logic        cal_done, dll_ready;
    logic        phy_pdb, phy_dll_en, seq_done, err_cal, err_dll, rate_warn;
    logic [1:0]  phy_freq_sel;

    int checks = 0;
    int errors = 0;
    int cal_dly = 0, dll_dly = 0;
    int cal_cnt = 0, dll_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_pwr_seq #(
        .CYC_PER_US (US),
        .DLL_TMO_US (TMO_US)
    ) u_phy_pwr_seq (
        .clk          (clk),
        .rst          (rst),
        .req_on       (req_on),
        .req_off      (req_off),
        .rate_hz      (rate_hz),
        .rate_valid   (rate_valid),
        .cal_done     (cal_done),
        .dll_ready    (dll_ready),
        .phy_pdb      (phy_pdb),
        .phy_dll_en   (phy_dll_en),
        .phy_freq_sel (phy_freq_sel),
        .seq_done     (seq_done),
        .err_cal      (err_cal),
        .err_dll      (err_dll),
        .rate_warn    (rate_warn)
    );

    // Analog PHY model
    always @(posedge clk) begin
        cal_cnt <= phy_pdb ? cal_cnt + 1 : 0;
        dll_cnt <= phy_dll_en ? dll_cnt + 1 : 0;
    end
    assign cal_done  = phy_pdb && (cal_cnt >= cal_dly);
    assign dll_ready = phy_dll_en && (dll_cnt >= dll_dly);

    // Port monitor
    bit   pdb_prev = 0, dll_prev = 0, pulse_prev = 0;
    int   low_run = 0;
    bit   bad_order = 0, short_settle = 0, dll_while_off = 0, wide_pulse = 0;
    bit   dll_rose = 0;
    logic [1:0] freq_at_rise = '0;
    int   pulse_cnt = 0;

    always @(negedge clk) begin
        bit pulse_now;
        pulse_now = seq_done | err_cal | err_dll;
        if (!rst) begin
            if (!dll_en_ok()) bad_order = 1;
            if (phy_pdb && !pdb_prev && low_run < SETTLE_MIN) short_settle = 1;
            if (phy_dll_en && !dll_prev) begin
                dll_rose = 1;
                freq_at_rise = phy_freq_sel;
                if (!phy_pdb) dll_while_off = 1;
            end
            if (pulse_now) pulse_cnt++;
            if (pulse_now && pulse_prev) wide_pulse = 1;
        end
        low_run    = phy_pdb ? 0 : low_run + 1;
        pdb_prev   = phy_pdb;
        dll_prev   = phy_dll_en;
        pulse_prev = pulse_now;
    end

    function automatic bit dll_en_ok();
        // DLL enable may only fall after power-down-bar is low
        return !(dll_prev && !phy_dll_en && phy_pdb);
    endfunction

    function automatic logic [1:0] exp_code(input logic [31:0] r, input bit v);
        if (!v)                return 2'd0;
        if (r < 32'd75_000_000)  return 2'd1;
        if (r < 32'd125_000_000) return 2'd2;
        if (r < 32'd175_000_000) return 2'd3;
        return 2'd0;
    endfunction

    function automatic bit exp_warn(input logic [31:0] r, input bit v);
        longint ideal, d;
        if (!v) return 0;
        case (exp_code(r, v))
            2'd1: ideal = 50_000_000;
            2'd2: ideal = 100_000_000;
            2'd3: ideal = 150_000_000;
            default: ideal = 200_000_000;
        endcase
        d = (longint'(r) > ideal) ? longint'(r) - ideal : ideal - longint'(r);
        return (longint'(r) > 200_000_000) || ((longint'(r) > 50_000_000) && (d > 15_000_000));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // kind: 0 done, 1 cal error, 2 dll error
    task automatic run_op(input bit on, input bit off, input logic [31:0] r, input bit v,
                          input int cdly, input int ddly, input bit inject);
        int exp_kind, got_kind, n, pc0;
        bit eff_on;
        eff_on = on;
        exp_kind = !eff_on ? 0 : (cdly > CAL_OK_MAX) ? 1 : (ddly > DLL_OK_MAX) ? 2 : 0;
        cal_dly = cdly; dll_dly = ddly;
        bad_order = 0; short_settle = 0; dll_while_off = 0; wide_pulse = 0; dll_rose = 0;
        pc0 = pulse_cnt;
        @(negedge clk);
        req_on = on; req_off = off; rate_hz = r; rate_valid = v;
        @(negedge clk);
        req_on = 0; req_off = 0;
        got_kind = -1;
        for (n = 0; n < 1000; n++) begin
            if (inject && n == 6) begin req_on = 1; req_off = 1; end
            else begin req_on = 0; req_off = 0; end
            if (seq_done) begin got_kind = 0; break; end
            if (err_cal)  begin got_kind = 1; break; end
            if (err_dll)  begin got_kind = 2; break; end
            @(negedge clk);
        end
        req_on = 0; req_off = 0;
        chk(got_kind == exp_kind, "R4/R6 outcome", got_kind, exp_kind);
        chk(rate_warn == exp_warn(r, v), "R8 rate_warn", rate_warn, exp_warn(r, v));
        chk(!bad_order, "R2 drop order", bad_order, 0);
        if (!eff_on) begin
            chk(!phy_pdb && !phy_dll_en, "R2 off leaves both low", {phy_pdb, phy_dll_en}, 0);
        end else begin
            chk(!short_settle, "R3 settle time", short_settle, 0);
            if (exp_kind == 1) begin
                chk(phy_pdb && !phy_dll_en && !dll_rose, "R4 dll stays off",
                    {phy_pdb, phy_dll_en}, 2);
            end else begin
                chk(phy_pdb && phy_dll_en, "R6 lines high", {phy_pdb, phy_dll_en}, 3);
                chk(freq_at_rise == exp_code(r, v), "R5/R7 band at dll rise",
                    freq_at_rise, exp_code(r, v));
                chk(!dll_while_off, "R5 dll after pdb", dll_while_off, 0);
            end
        end
        repeat (inject ? 40 : 3) @(negedge clk);
        chk(!wide_pulse, "R10 pulse width", wide_pulse, 0);
        chk(pulse_cnt - pc0 == 1, "R9/R10 single result", pulse_cnt - pc0, 1);
        if (inject) chk(phy_pdb == eff_on, "R9 no restart", phy_pdb, eff_on);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!phy_pdb && !phy_dll_en && phy_freq_sel == 2'd0 && !seq_done && !err_cal && !err_dll,
            "R1 reset state", {phy_pdb, phy_dll_en, phy_freq_sel}, 0);

        // Directed band and warning edges (R7, R8)
        run_op(1, 0, 32'd74_999_999, 1, 5, 20, 0);
        run_op(1, 0, 32'd75_000_000, 1, 5, 20, 0);
        run_op(1, 0, 32'd124_999_999, 1, 5, 20, 0);
        run_op(1, 0, 32'd125_000_000, 1, 5, 20, 0);
        run_op(1, 0, 32'd174_999_999, 1, 5, 20, 0);
        run_op(1, 0, 32'd175_000_000, 1, 5, 20, 0);
        run_op(1, 0, 32'd200_000_000, 1, 5, 20, 0);
        run_op(1, 0, 32'd200_000_001, 1, 5, 20, 0);
        run_op(1, 0, 32'd65_000_000, 1, 5, 20, 0);
        run_op(1, 0, 32'd65_000_001, 1, 5, 20, 0);
        run_op(1, 0, 32'd35_000_000, 1, 5, 20, 0);
        run_op(1, 0, 32'd300_000_000, 0, 5, 20, 0);   // no rate: code 0, no warn
        // Power-down after power-up (R2)
        run_op(0, 1, 32'd100_000_000, 1, 5, 20, 0);
        // Timeouts (R4, R6)
        run_op(1, 0, 32'd50_000_000, 1, CAL_BAD, 20, 0);
        run_op(1, 0, 32'd50_000_000, 1, 5, DLL_BAD, 0);
        run_op(1, 0, 32'd150_000_000, 1, 0, DLL_OK_MAX, 0);
        // Both requests together: power-up wins; mid-sequence requests ignored (R9)
        run_op(1, 1, 32'd100_000_000, 1, 5, 30, 1);
        run_op(0, 1, 32'd100_000_000, 1, 5, 30, 1);

        // Reset while powered (R1)
        run_op(1, 0, 32'd150_000_000, 1, 5, 20, 0);
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        chk(!phy_pdb && !phy_dll_en && phy_freq_sel == 2'd0, "R1 reset after power-up",
            {phy_pdb, phy_dll_en, phy_freq_sel}, 0);
        rst = 0;
        @(negedge clk);

        // Constrained random mix
        for (int i = 0; i < 40; i++) begin
            bit on, v;
            int cd, dd;
            logic [31:0] r;
            on = ($urandom % 4) != 0;
            v  = ($urandom % 8) != 0;
            r  = $urandom_range(0, 260_000_000);
            cd = (($urandom % 100) < 85) ? $urandom_range(0, CAL_OK_MAX) : CAL_BAD;
            dd = (($urandom % 100) < 80) ? $urandom_range(0, DLL_OK_MAX) : DLL_BAD;
            run_op(on, !on, r, v, cd, dd, ($urandom % 6) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule